// File: doc/BRIEF.md
# Cascadable Dual 8-bit Pulse Accumulator

This block holds two 8-bit counters. Each counter counts qualified edges from its own pulse input. Both inputs go through a two-flop synchronizer. A third flop gives the previous level, so that a rising or falling transition can be picked out. A control bit selects which of the two transitions counts. When the cascade bit is set, the two counters act as one 16-bit accumulator. The counter at register address 0 becomes the high byte and the counter at address 1 the low byte. The high byte then advances only on the carry out of the low byte, and its own pulse input is not used.

A simple synchronous register bus reaches every register. A byte access moves 8 bits. A word access reads or writes both count bytes in the same clock cycle, so software sees a coherent 16-bit value that two separate byte accesses may not give. In cascade mode, a wrap of the high byte raises a sticky overflow flag. Software clears the flag by writing 1 to it. An interrupt output follows the flag, gated by an enable bit.

Top module: `pa_cascade_accum`

## Requirements
- R1: Register map for byte access: address 0 is the high count byte, address 1 the low count byte, address 2 control (bit 0 cascade enable, bit 1 count falling edges when 1 and rising edges when 0, bit 2 interrupt enable), address 3 status (bit 0 overflow flag). After reset, both counts, control, status and `irq_o` are 0. Reads complete one cycle after the request, with `bus_rvalid_o` high.
- R2: With cascade disabled, each counter adds one for each qualified edge on its own pulse input, and the two counters do not affect each other.
- R3: With control bit 1 set, only falling transitions are counted and a rising transition leaves the count unchanged. With control bit 1 clear, the reverse holds.
- R4: With cascade enabled, the low byte counts the low pulse input, and the high byte adds one in the same cycle in which the low byte wraps from 0xFF to 0x00.
- R5: With cascade enabled, edges on the high pulse input do not change the high byte.
- R6: The overflow flag is set when the high byte wraps from 0xFF to 0x00 in cascade mode, and only then. The flag stays set until it is cleared.
- R7: Writing status with bit 0 = 1 clears the flag, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_o` is high exactly while the overflow flag and control bit 2 are both 1.
- R9: A word access (`bus_word_i` = 1) reads high byte in bits 15:8 and low byte in bits 7:0, both sampled in the same cycle. A word write loads both bytes at once, with no carry from low to high.
- R10: A register write to a count byte takes priority over an increment of that byte in the same cycle. A low byte that is written produces no carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_hi_i | input | 1 | Asynchronous pulse input of the high counter |
| pulse_lo_i | input | 1 | Asynchronous pulse input of the low counter |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | Write when high |
| bus_rd_i | input | 1 | Read when high (ignored during a write) |
| bus_word_i | input | 1 | Word access of both count bytes |
| bus_addr_i | input | 2 | Byte register address |
| bus_wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata_o | output | 16 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The counters are driven with bursts of whole pulses on each input, a single held level followed by its release (to tell rising-edge counting from falling-edge counting), and pulses on the high input while cascade is on (to show they are ignored). Word writes to values just below a wrap, such as 0x12FE and 0xFFFF, show whether the carry into the high byte and the overflow flag come at the right count. Timing a byte write to land in the cycle in which an edge matures shows whether the write or the increment wins. A comparison of byte reads with word reads after a single-byte write shows that the two bytes are handled separately.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic [1:0] {
    REG_CNT_HI = 2'd0,
    REG_CNT_LO = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } pa_reg_e;

  typedef struct packed {
    logic irq_en;
    logic falling;
    logic cascade;
  } pa_ctrl_t;

  localparam int CTRL_BITS = 3;

  function automatic pa_ctrl_t ctrl_from_byte(input logic [CTRL_BITS-1:0] b);
    pa_ctrl_t c;
    c.cascade = b[0];
    c.falling = b[1];
    c.irq_en  = b[2];
    return c;
  endfunction

endpackage

// File: rtl/pa_edge_sync.sv
module pa_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic falling_i,
  output logic hit_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;
  logic          cur_lvl;
  logic          prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], pin_i};
  end

  assign cur_lvl  = chain[LAST-1];
  assign prev_lvl = chain[LAST];
  assign hit_o    = falling_i ? (prev_lvl & ~cur_lvl) : (cur_lvl & ~prev_lvl);

  AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (cur_lvl != prev_lvl)); // R3

endmodule

// File: rtl/pa_count_byte.sv
module pa_count_byte #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  function automatic logic [CW:0] bump(input logic [CW-1:0] v);
    return {1'b0, v} + {{CW{1'b0}}, 1'b1};
  endfunction

  logic          step;
  logic [CW:0]   nxt;

  assign step   = inc_i & ~load_i;
  assign nxt    = bump(count_o);
  assign wrap_o = step & nxt[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (step)   count_o <= nxt[CW-1:0];
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(load_val_i)); // R10

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> count_o == CW'($past(count_o) + 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(count_o)); // R2

endmodule

// File: rtl/pa_cascade_accum.sv
module pa_cascade_accum
  import pa_pkg::*;
#(
  parameter int CW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_hi_i,
  input  logic          pulse_lo_i,
  input  logic          bus_sel_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic          bus_word_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [2*CW-1:0] bus_wdata_i,
  output logic [2*CW-1:0] bus_rdata_o,
  output logic          bus_rvalid_o,
  output logic          irq_o
);
  localparam int DW = 2 * CW;
  localparam int NCH = 2;

  // bus decode
  logic wr_byte, wr_word, rd_req;
  logic ld_hi, ld_lo, ctrl_wr, stat_clr;
  logic [CW-1:0] val_hi, val_lo;

  assign wr_byte  = bus_sel_i & bus_wr_i & ~bus_word_i;
  assign wr_word  = bus_sel_i & bus_wr_i & bus_word_i;
  assign rd_req   = bus_sel_i & bus_rd_i & ~bus_wr_i;
  assign ld_hi    = wr_word | (wr_byte && bus_addr_i == REG_CNT_HI);
  assign ld_lo    = wr_word | (wr_byte && bus_addr_i == REG_CNT_LO);
  assign ctrl_wr  = wr_byte && bus_addr_i == REG_CTRL;
  assign stat_clr = wr_byte && bus_addr_i == REG_STAT && bus_wdata_i[0];
  assign val_hi   = wr_word ? bus_wdata_i[DW-1:CW] : bus_wdata_i[CW-1:0];
  assign val_lo   = bus_wdata_i[CW-1:0];

  // control register
  pa_ctrl_t ctl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl <= '0;
    else if (ctrl_wr) ctl <= ctrl_from_byte(bus_wdata_i[CTRL_BITS-1:0]);
  end

  // edge qualification, channel 0 = low pin, channel 1 = high pin
  logic [NCH-1:0] pins, hit;
  assign pins = {pulse_hi_i, pulse_lo_i};

  for (genvar g = 0; g < NCH; g++) begin : g_edge
    pa_edge_sync #(.STAGES(STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pins[g]),
      .falling_i(ctl.falling),
      .hit_o    (hit[g])
    );
  end

  // counters
  logic [CW-1:0] cnt_hi, cnt_lo;
  logic          wrap_hi, wrap_lo;
  logic          inc_hi;

  assign inc_hi = ctl.cascade ? wrap_lo : hit[1];

  pa_count_byte #(.CW(CW)) u_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ld_lo),
    .load_val_i(val_lo),
    .inc_i     (hit[0]),
    .count_o   (cnt_lo),
    .wrap_o    (wrap_lo)
  );

  pa_count_byte #(.CW(CW)) u_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ld_hi),
    .load_val_i(val_hi),
    .inc_i     (inc_hi),
    .count_o   (cnt_hi),
    .wrap_o    (wrap_hi)
  );

  // overflow flag, set beats clear
  logic ovf_set, ovf_flag;
  assign ovf_set = ctl.cascade & wrap_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (ovf_set)  ovf_flag <= 1'b1;
    else if (stat_clr) ovf_flag <= 1'b0;
  end

  assign irq_o = ovf_flag & ctl.irq_en;

  // registered read path
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_word_i) rd_mux = {cnt_hi, cnt_lo};
    else begin
      case (bus_addr_i)
        REG_CNT_HI: rd_mux[CW-1:0] = cnt_hi;
        REG_CNT_LO: rd_mux[CW-1:0] = cnt_lo;
        REG_CTRL:   rd_mux[CTRL_BITS-1:0] = {ctl.irq_en, ctl.falling, ctl.cascade};
        default:    rd_mux[0] = ovf_flag;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= rd_req;
      if (rd_req) bus_rdata_o <= rd_mux;
    end
  end

  AST_CARRY_INTO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cascade && wrap_lo && !ld_hi) |=> cnt_hi == CW'($past(cnt_hi) + 1'b1)); // R4

  AST_HI_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.cascade && !wrap_lo && !ld_hi) |=> $stable(cnt_hi)); // R5

  AST_OVERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.cascade && !ovf_flag) |=> !ovf_flag); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_clr) |=> ovf_flag); // R7

  AST_WORD_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && bus_word_i) |=> bus_rdata_o == {$past(cnt_hi), $past(cnt_lo)}); // R9

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid_o); // R1

endmodule

// File: tb/pa_cascade_accum_test.sv
module pa_cascade_accum_test;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_hi = 1'b0, pulse_lo = 1'b0;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0, word = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rvalid, irq;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  pa_cascade_accum uut (
    .clk(clk), .rst_n(rst_n),
    .pulse_hi_i(pulse_hi), .pulse_lo_i(pulse_lo),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd), .bus_word_i(word),
    .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  // monitor: compares each returned read with the scoreboard head
  always @(negedge clk) begin
    if (rvalid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic check_irq(input logic exp, input string t);
    vectors++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; word = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; word = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic w, input logic [15:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    sel = 1'b1; rd = 1'b1; word = w; addr = a;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0; word = 1'b0;
  endtask

  task automatic pulses(input bit hi_ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hi_ch) pulse_hi = 1'b1; else pulse_lo = 1'b1;
      repeat (4) @(negedge clk);
      if (hi_ch) pulse_hi = 1'b0; else pulse_lo = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and register map
    bus_read(2'd0, 1'b0, 16'h0000, "R1 high byte after reset");
    bus_read(2'd1, 1'b0, 16'h0000, "R1 low byte after reset");
    bus_read(2'd2, 1'b0, 16'h0000, "R1 control after reset");
    bus_read(2'd3, 1'b0, 16'h0000, "R1 status after reset");
    check_irq(1'b0, "R1 irq after reset");

    // R2 independent counting
    pulses(1'b0, 5);
    pulses(1'b1, 3);
    bus_read(2'd1, 1'b0, 16'h0005, "R2 low counts own pin");
    bus_read(2'd0, 1'b0, 16'h0003, "R2 high counts own pin");

    // R3 falling-edge mode: held level rises without counting
    bus_write(2'd2, 1'b0, 16'h0002);
    bus_read(2'd2, 1'b0, 16'h0002, "R1 control readback");
    @(negedge clk); pulse_lo = 1'b1;
    settle();
    bus_read(2'd1, 1'b0, 16'h0005, "R3 rise ignored in falling mode");
    @(negedge clk); pulse_lo = 1'b0;
    settle();
    bus_read(2'd1, 1'b0, 16'h0006, "R3 fall counted in falling mode");

    // R9 word write, R4 cascade carry, R5 high pin ignored
    bus_write(2'd2, 1'b0, 16'h0001);
    bus_write(2'd0, 1'b1, 16'h12FE);
    bus_read(2'd0, 1'b1, 16'h12FE, "R9 word write loads both bytes");
    pulses(1'b0, 3);
    bus_read(2'd0, 1'b1, 16'h1301, "R4 carry into high byte");
    pulses(1'b1, 4);
    bus_read(2'd0, 1'b1, 16'h1301, "R5 high pin ignored in cascade");
    bus_read(2'd3, 1'b0, 16'h0000, "R6 no flag before wrap");

    // R6 overflow, R8 interrupt gating, R7 clear
    bus_write(2'd0, 1'b1, 16'hFFFF);
    pulses(1'b0, 1);
    bus_read(2'd0, 1'b1, 16'h0000, "R4 full wrap to zero");
    bus_read(2'd3, 1'b0, 16'h0001, "R6 flag set on high wrap");
    check_irq(1'b0, "R8 irq masked while disabled");
    bus_write(2'd2, 1'b0, 16'h0005);
    @(negedge clk);
    check_irq(1'b1, "R8 irq when flag and enable");
    bus_write(2'd3, 1'b0, 16'h0000);
    bus_read(2'd3, 1'b0, 16'h0001, "R7 writing 0 keeps flag");
    bus_write(2'd3, 1'b0, 16'h0001);
    bus_read(2'd3, 1'b0, 16'h0000, "R7 writing 1 clears flag");
    check_irq(1'b0, "R8 irq drops after clear");

    // R10 byte write lands in the cycle of a matured edge
    bus_write(2'd0, 1'b1, 16'h07FF);
    @(negedge clk); pulse_lo = 1'b1;
    @(negedge clk);
    bus_write(2'd1, 1'b0, 16'h0040);
    settle();
    pulse_lo = 1'b0;
    settle();
    bus_read(2'd0, 1'b1, 16'h0740, "R10 write wins, no carry");

    // R6 no flag in independent mode
    bus_write(2'd2, 1'b0, 16'h0000);
    bus_write(2'd0, 1'b0, 16'h00FF);
    pulses(1'b1, 1);
    bus_read(2'd0, 1'b0, 16'h0000, "R2 high wraps independently");
    bus_read(2'd3, 1'b0, 16'h0000, "R6 no flag when not cascaded");

    // R9 byte write touches one byte only
    bus_write(2'd1, 1'b0, 16'h0034);
    bus_read(2'd0, 1'b1, 16'h0034, "R9 byte write then word read");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: actual %0d reads pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule